// File: doc/BRIEF.md
# Multi-Channel PWM Generator with Register Bus

This block produces up to eight independent pulse-width-modulated outputs. Software sets them up over a simple 32-bit register bus that has separate write-enable and read-enable strobes. Each channel has its own register bank, which holds the following:
- a control word with a mode bit and a clock-divider exponent;
- a 13-bit period count;
- a 13-bit duty threshold.

A single global word turns channels on and off. A one-bit clock-source register is also provided. It can be written and read back, and it has no other effect.

A running channel divides the input clock by a power of two, from 1 to 128, and steps a counter from zero to period minus one. Its output is high while the count is below the threshold. The period, threshold and divider are copied into working copies only when a period completes, so a change to the settings never cuts a pulse short. A channel's output is held low whenever that channel is switched off or its mode bit is clear.

The bank base addresses are spaced unevenly. A build option moves the period and threshold registers of channels 3 and above up by one word.

Top module: `pwm_bank_ctrl`

## Requirements
- R1: After reset, every register reads zero, every output is low, and the read data bus is zero.
- R2: Bit n of the word at address 0x000 enables channel n. Bits at or above the channel count read back as zero and have no effect.
- R3: The channel banks are based at 0x010, 0x050, 0x090, 0x0D0, 0x110, 0x150, 0x190 and 0x220 for channels 0 to 7.
  - The control word sits at bank +0x00.
  - Control bit 15 selects the periodic mode.
  - Control bits [2:0] hold the divider exponent d.
  - All other control bits read as zero.
- R4: The period register sits at bank +0x2C and the threshold register at bank +0x30. Both are 13 bits wide, and their upper bits read as zero. When the remap option is set, channels 3 and above move these registers to +0x30 and +0x34 respectively.
- R5: Address 0x210 holds a one-bit clock-source register. It resets to 0 and can be written and read back; bits 31:1 read as zero.
- R6: A read of any address that maps to no register returns zero.
- R7: With period P and threshold T, where 0 < T < P, the output stays high for 2^d·T input clocks and then low for 2^d·(P−T) input clocks. This holds for d from 0 to 7 and for P up to 8191.
- R8: A threshold of 0 keeps the output low at all times. A threshold greater than or equal to the period keeps the output high at all times.
- R9: New period, threshold and divider values written while a channel is running take effect only at the next counter wrap. The period that is in progress completes with its old timing.
- R10: A channel that is disabled, or whose mode bit is clear, drives its output low and resets its counter and prescaler. Once it is re-enabled, the output goes high within two clocks and begins a full high phase.
- R11: Read data appears on the clock edge that samples the read enable, and it stays unchanged until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock for the bus and all channels |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one clock per write |
| bus_re | input | 1 | Read strobe, one clock per read |
| bus_rdata | output | 32 | Registered read data |
| pwm_o | output | NUM_CH | One PWM output per channel |

## Verification
A stale working copy of the period or threshold, or a prescaler that slips, shows up directly in the measured high and low times. Such an error is visible within one output period of the channel concerned, which is at most 2^d·P clocks. A counter that runs past the period, or a channel that keeps running after it has been disabled, makes an output stay high or low for longer than expected. This appears within two clocks of the disable, or within one period of the counter fault. A decode slip, such as a wrong bank base or a misapplied remap, appears on the very next read-back, because the written value lands in the wrong register or reads back as zero.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

   localparam int unsigned BUS_W    = 32;
   localparam int unsigned DIV_W    = 3;
   localparam int unsigned MODE_BIT = 15;

   // global register addresses
   localparam int unsigned ADDR_ENABLE = 'h000;
   localparam int unsigned ADDR_CLKSEL = 'h210;

   // offsets inside a channel bank
   localparam int unsigned OFS_CTRL      = 'h00;
   localparam int unsigned OFS_WIDTH     = 'h2C;
   localparam int unsigned OFS_THRES     = 'h30;
   localparam int unsigned OFS_WIDTH_ALT = 'h30;
   localparam int unsigned OFS_THRES_ALT = 'h34;

   typedef struct packed {
      logic             mode;
      logic [DIV_W-1:0] div;
   } chan_ctrl_t;

   // banks are 0x40 apart for channels 0..6; the last bank is displaced
   function automatic int unsigned bank_base(input int unsigned ch);
      return (ch < 7) ? ('h10 + 'h40 * ch) : 'h220;
   endfunction

endpackage

// File: rtl/pwm_chan_core.sv
module pwm_chan_core
   import pwm_bank_pkg::*;
#(
   parameter int unsigned CNT_W = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic [DIV_W-1:0] div_i,
   input  logic [CNT_W-1:0] per_i,
   input  logic [CNT_W-1:0] thr_i,
   output logic             pwm_o
);
   localparam int unsigned PRE_W = (1 << DIV_W) - 1;

   logic             run_q;
   logic [PRE_W-1:0] pre_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] per_sh;
   logic [CNT_W-1:0] thr_sh;
   logic [DIV_W-1:0] div_sh;
   logic [PRE_W-1:0] pre_mask;
   logic             tick;
   logic             wrap;

   assign pre_mask = ~({PRE_W{1'b1}} << div_sh);
   assign tick     = run_q && (pre_q == pre_mask);
   assign wrap     = tick && (({1'b0, cnt_q} + 1'b1) >= {1'b0, per_sh});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         pre_q  <= '0;
         cnt_q  <= '0;
         per_sh <= '0;
         thr_sh <= '0;
         div_sh <= '0;
      end else if (!en_i) begin
         run_q <= 1'b0;
         pre_q <= '0;
         cnt_q <= '0;
      end else if (!run_q || wrap) begin
         run_q  <= 1'b1;
         pre_q  <= '0;
         cnt_q  <= '0;
         per_sh <= per_i;
         thr_sh <= thr_i;
         div_sh <= div_i;
      end else if (tick) begin
         pre_q <= '0;
         cnt_q <= cnt_q + 1'b1;
      end else begin
         pre_q <= pre_q + 1'b1;
      end
   end

   assign pwm_o = run_q && (cnt_q < thr_sh);

   // R10
   off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> !pwm_o);
   // R7
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && per_sh != '0) |-> (cnt_q < per_sh));
   // R7
   pre_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pre_q <= pre_mask);
   // R9
   shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && !wrap) |=> ($stable(per_sh) && $stable(thr_sh) && $stable(div_sh)));

endmodule

// File: rtl/pwm_bank_regs.sv
module pwm_bank_regs
   import pwm_bank_pkg::*;
#(
   parameter int unsigned NUM_CH = 8,
   parameter int unsigned CNT_W  = 13,
   parameter int unsigned ADDR_W = 12,
   parameter bit          REMAP  = 1'b0
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [ADDR_W-1:0]           addr,
   input  logic [BUS_W-1:0]            wdata,
   input  logic                        we,
   input  logic                        re,
   output logic [BUS_W-1:0]            rdata,
   output logic [NUM_CH-1:0]           en_o,
   output chan_ctrl_t [NUM_CH-1:0]     ctrl_o,
   output logic [NUM_CH-1:0][CNT_W-1:0] per_o,
   output logic [NUM_CH-1:0][CNT_W-1:0] thr_o
);
   logic [NUM_CH-1:0]            en_q;
   logic                         clksel_q;
   logic                         hit_en;
   logic                         hit_cs;
   logic [NUM_CH-1:0]            hit_ch;
   logic [NUM_CH-1:0][BUS_W-1:0] rd_ch;
   logic [BUS_W-1:0]             rd_nxt;
   logic                         unused_wdata_bits;

   assign unused_wdata_bits = ^wdata;
   assign hit_en = (addr == ADDR_W'(ADDR_ENABLE));
   assign hit_cs = (addr == ADDR_W'(ADDR_CLKSEL));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q     <= '0;
         clksel_q <= 1'b0;
      end else if (we) begin
         if (hit_en) en_q     <= wdata[NUM_CH-1:0];
         if (hit_cs) clksel_q <= wdata[0];
      end
   end

   for (genvar g = 0; g < NUM_CH; g++) begin : g_bank
      localparam int unsigned BASE = bank_base(g);
      localparam bit          ALT  = REMAP && (g > 2);
      localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(BASE + OFS_CTRL);
      localparam logic [ADDR_W-1:0] A_PER  = ADDR_W'(BASE + (ALT ? OFS_WIDTH_ALT : OFS_WIDTH));
      localparam logic [ADDR_W-1:0] A_THR  = ADDR_W'(BASE + (ALT ? OFS_THRES_ALT : OFS_THRES));

      logic             h_ctrl, h_per, h_thr;
      chan_ctrl_t       ctrl_q;
      logic [CNT_W-1:0] per_q, thr_q;
      logic [BUS_W-1:0] rd_v;

      assign h_ctrl = (addr == A_CTRL);
      assign h_per  = (addr == A_PER);
      assign h_thr  = (addr == A_THR);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ctrl_q <= '0;
            per_q  <= '0;
            thr_q  <= '0;
         end else if (we) begin
            if (h_ctrl) begin
               ctrl_q.mode <= wdata[MODE_BIT];
               ctrl_q.div  <= wdata[DIV_W-1:0];
            end
            if (h_per) per_q <= wdata[CNT_W-1:0];
            if (h_thr) thr_q <= wdata[CNT_W-1:0];
         end
      end

      always_comb begin
         rd_v = '0;
         if (h_ctrl) begin
            rd_v[MODE_BIT]  = ctrl_q.mode;
            rd_v[DIV_W-1:0] = ctrl_q.div;
         end else if (h_per) begin
            rd_v[CNT_W-1:0] = per_q;
         end else if (h_thr) begin
            rd_v[CNT_W-1:0] = thr_q;
         end
      end

      assign rd_ch[g]  = rd_v;
      assign hit_ch[g] = h_ctrl | h_per | h_thr;
      assign ctrl_o[g] = ctrl_q;
      assign per_o[g]  = per_q;
      assign thr_o[g]  = thr_q;
   end

   always_comb begin
      rd_nxt = '0;
      if (hit_en) rd_nxt[NUM_CH-1:0] = en_q;
      if (hit_cs) rd_nxt[0] = clksel_q;
      for (int i = 0; i < NUM_CH; i++) rd_nxt = rd_nxt | rd_ch[i];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  rdata <= '0;
      else if (re) rdata <= rd_nxt;
   end

   assign en_o = en_q;

   // R6
   unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (re && !hit_en && !hit_cs && hit_ch == '0) |=> (rdata == '0));
   // R11
   rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !re |=> $stable(rdata));
   // R5
   clksel_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (re && hit_cs) |=> (rdata[BUS_W-1:1] == '0));

endmodule

// File: rtl/pwm_bank_ctrl.sv
module pwm_bank_ctrl
   import pwm_bank_pkg::*;
#(
   parameter int unsigned NUM_CH = 8,
   parameter int unsigned CNT_W  = 13,
   parameter int unsigned ADDR_W = 12,
   parameter bit          REMAP  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   input  logic              bus_we,
   input  logic              bus_re,
   output logic [31:0]       bus_rdata,
   output logic [NUM_CH-1:0] pwm_o
);
   if (NUM_CH < 1 || NUM_CH > 8) begin : g_bad_ch
      $error("NUM_CH must lie in 1..8");
   end
   if (CNT_W < 2 || CNT_W > MODE_BIT) begin : g_bad_cnt
      $error("CNT_W must lie in 2..15");
   end
   if (ADDR_W < 10 || ADDR_W > 16) begin : g_bad_addr
      $error("ADDR_W must lie in 10..16");
   end

   logic [NUM_CH-1:0]             en_vec;
   chan_ctrl_t [NUM_CH-1:0]       ctrl_vec;
   logic [NUM_CH-1:0][CNT_W-1:0]  per_vec;
   logic [NUM_CH-1:0][CNT_W-1:0]  thr_vec;

   pwm_bank_regs #(
      .NUM_CH (NUM_CH),
      .CNT_W  (CNT_W),
      .ADDR_W (ADDR_W),
      .REMAP  (REMAP)
   ) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .addr   (bus_addr),
      .wdata  (bus_wdata),
      .we     (bus_we),
      .re     (bus_re),
      .rdata  (bus_rdata),
      .en_o   (en_vec),
      .ctrl_o (ctrl_vec),
      .per_o  (per_vec),
      .thr_o  (thr_vec)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
      pwm_chan_core #(
         .CNT_W (CNT_W)
      ) u_core (
         .clk   (clk),
         .rst_n (rst_n),
         .en_i  (en_vec[c] & ctrl_vec[c].mode),
         .div_i (ctrl_vec[c].div),
         .per_i (per_vec[c]),
         .thr_i (thr_vec[c]),
         .pwm_o (pwm_o[c])
      );
   end

   // R1
   reset_quiet_chk: assert property (@(posedge clk)
      !rst_n |=> (pwm_o == '0 && bus_rdata == '0));

endmodule

// File: tb/pwm_bank_ctrl_bench.sv
module pwm_bank_ctrl_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic        bus_we = 1'b0;
   logic        bus_re = 1'b0;
   logic [31:0] rdata_a, rdata_b;
   logic [7:0]  pwm_a;
   logic [5:0]  pwm_b;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;
   logic [31:0] rd_a, rd_b;
   logic [7:0]  en_shadow = '0;

   always #2.5 clk = ~clk;

   pwm_bank_ctrl #(.NUM_CH(8), .CNT_W(13), .ADDR_W(12), .REMAP(1'b0)) u_pwm_bank_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(rdata_a), .pwm_o(pwm_a));

   pwm_bank_ctrl #(.NUM_CH(6), .CNT_W(13), .ADDR_W(12), .REMAP(1'b1)) u_pwm_bank_ctrl_remap (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(rdata_b), .pwm_o(pwm_b));

   function automatic int base(input int ch);
      return (ch < 7) ? (16 + 64 * ch) : 'h220;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic bus_wr(input int a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = 12'(a); bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic bus_rd(input int a);
      @(negedge clk);
      bus_addr = 12'(a); bus_re = 1'b1;
      @(negedge clk);
      bus_re = 1'b0;
      rd_a = rdata_a; rd_b = rdata_b;
   endtask

   task automatic set_en(input int ch, input bit on);
      en_shadow[ch] = on;
      bus_wr('h000, {24'h0, en_shadow});
   endtask

   task automatic cfg(input int ch, input int dv, input int per, input int thr);
      bus_wr(base(ch) + 'h00, 32'h8000 | 32'(dv));
      bus_wr(base(ch) + 'h2C, 32'(per));
      bus_wr(base(ch) + 'h30, 32'(thr));
   endtask

   task automatic sync_rise(input int ch);
      int t = 0;
      while (pwm_a[ch] !== 1'b0 && t < 40000) begin @(negedge clk); t++; end
      t = 0;
      while (pwm_a[ch] !== 1'b1 && t < 40000) begin @(negedge clk); t++; end
   endtask

   task automatic count_phase(input int ch, input logic lvl, output int n);
      n = 0;
      while (pwm_a[ch] === lvl && n < 40000) begin @(negedge clk); n++; end
   endtask

   task automatic measure(input int ch, input int hi, input int lo, input string req);
      int n;
      sync_rise(ch);
      count_phase(ch, 1'b1, n); chk(req, 32'(n), 32'(hi));
      count_phase(ch, 1'b0, n); chk(req, 32'(n), 32'(lo));
   endtask

   task automatic hold_level(input int ch, input logic lvl, input int cycles, input string req);
      int bad = 0;
      for (int i = 0; i < cycles; i++) begin
         @(negedge clk);
         if (pwm_a[ch] !== lvl) bad++;
      end
      chk(req, 32'(bad), 32'd0);
   endtask

   task automatic t_reset;
      chk("R1 outputs", {24'h0, pwm_a}, 32'h0);
      chk("R1 rdata", rdata_a, 32'h0);
      bus_rd('h000);      chk("R1 enable", rd_a, 0);
      bus_rd('h210);      chk("R1 clksel", rd_a, 0);
      bus_rd(base(0));    chk("R1 ctrl0", rd_a, 0);
      bus_rd(base(7)+'h30); chk("R1 thr7", rd_a, 0);
   endtask

   task automatic t_regs;
      bus_wr(base(5), 32'hFFFF_FFFF);
      bus_rd(base(5));        chk("R3 ctrl fields", rd_a, 32'h0000_8007);
      bus_wr(base(5), 32'h0);
      bus_wr(base(7)+'h2C, 32'hFFFF_FFFF);
      bus_rd(base(7)+'h2C);   chk("R4 period width", rd_a, 32'h1FFF);
      bus_wr(base(3)+'h30, 32'd100);
      bus_rd(base(3)+'h30);   chk("R4 remap width", rd_b, 32'd100);
      bus_rd(base(3)+'h2C);   chk("R4 remap old slot", rd_b, 32'd0);
      bus_wr(base(1)+'h2C, 32'd77);
      bus_rd(base(1)+'h2C);   chk("R4 low channel unmoved", rd_b, 32'd77);
      bus_wr('h210, 32'hFFFF_FFFF);
      bus_rd('h210);          chk("R5 clksel set", rd_a, 32'd1);
      bus_wr('h210, 32'h0);
      bus_rd('h210);          chk("R5 clksel clear", rd_a, 32'd0);
      bus_rd('h004);          chk("R6 unmapped 004", rd_a, 0);
      bus_rd('h200);          chk("R6 unmapped 200", rd_a, 0);
      bus_rd('h3FC);          chk("R6 unmapped 3FC", rd_a, 0);
      bus_wr('h000, 32'hFF);
      bus_rd('h000);          chk("R2 upper bits zero", rd_b, 32'h3F);
      chk("R2 eight channels", rd_a, 32'hFF);
      chk("R10 mode clear keeps low", {24'h0, pwm_a}, 32'h0);
      repeat (5) @(negedge clk);
      chk("R11 rdata hold", rdata_a, 32'hFF);
      bus_wr('h000, 32'h0);
      en_shadow = '0;
   endtask

   task automatic t_wave;
      cfg(0, 0, 10, 3);   set_en(0, 1'b1); measure(0, 3, 7, "R7 d0");
      cfg(2, 2, 20, 5);   set_en(2, 1'b1); measure(2, 20, 60, "R7 d2");
      cfg(7, 7, 6, 2);    set_en(7, 1'b1); measure(7, 256, 512, "R7 d7");
      cfg(4, 3, 100, 99); set_en(4, 1'b1); measure(4, 792, 8, "R7 d3");
      cfg(6, 0, 8191, 8190); set_en(6, 1'b1); measure(6, 8190, 1, "R7 max period");
      set_en(6, 1'b0);
   endtask

   task automatic t_const;
      cfg(1, 1, 12, 0);  set_en(1, 1'b1); hold_level(1, 1'b0, 100, "R8 zero threshold");
      bus_wr(base(1)+'h30, 32'd12);
      repeat (30) @(negedge clk);
      hold_level(1, 1'b1, 100, "R8 threshold equals period");
      bus_wr(base(1)+'h30, 32'd500);
      repeat (30) @(negedge clk);
      hold_level(1, 1'b1, 100, "R8 threshold above period");
      set_en(1, 1'b0);
   endtask

   task automatic t_update;
      int nh, nl;
      cfg(3, 0, 40, 10); set_en(3, 1'b1);
      sync_rise(3);
      fork
         begin
            count_phase(3, 1'b1, nh);
            count_phase(3, 1'b0, nl);
         end
         begin
            bus_wr(base(3)+'h2C, 32'd60);
            bus_wr(base(3)+'h30, 32'd50);
         end
      join
      chk("R9 old high kept", 32'(nh), 32'd10);
      chk("R9 old low kept", 32'(nl), 32'd30);
      count_phase(3, 1'b1, nh);
      chk("R9 new high", 32'(nh), 32'd50);
      measure(3, 50, 10, "R9 new steady");
   endtask

   task automatic t_disable;
      int t = 0;
      int nh;
      set_en(0, 1'b0);
      repeat (2) @(negedge clk);
      hold_level(0, 1'b0, 50, "R10 disabled low");
      measure(2, 20, 60, "R2 neighbour unaffected");
      bus_wr(base(0), 32'h0);
      set_en(0, 1'b1);
      hold_level(0, 1'b0, 40, "R10 mode bit clear");
      @(negedge clk);
      bus_addr = 12'(base(0)); bus_wdata = 32'h8000; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
      while (pwm_a[0] !== 1'b1 && t < 10) begin @(negedge clk); t++; end
      chk("R10 restart latency", 32'(t <= 2), 32'd1);
      count_phase(0, 1'b1, nh);
      chk("R10 full first high", 32'(nh), 32'd3);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_regs();
      t_wave();
      t_const();
      t_update();
      t_disable();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule